// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Overrun

This block receives characters on an asynchronous serial line. A baud tick supplied from outside runs at sixteen times the bit rate. The block looks for a falling edge on the line and confirms the start bit at its centre. It then samples eight data bits, least significant first, at their centres. An optional parity bit follows, then a stop bit. A finished character moves into a receive buffer register, and the block raises a finished flag together with per-character parity and framing flags.

The host reads the buffer through a simple register interface. It reports the read with a one-cycle strobe, and it owns a receive-enable bit. If a new character completes while the previous one is still unread, the block raises an overrun flag. The new character is dropped and the buffer keeps the older one. From then on the overrun state is locked: frames are still shifted in but are thrown away, and buffer reads no longer clear any flag. The only way back to normal operation is to drop receive enable. This clears every flag and returns the receiver to idle.

Top module: `uart_rx`

## Requirements
- R1: A frame consists of a low start bit, eight data bits sent least significant first, an optional parity bit and a high stop bit. A completed frame loads its data into `rbuf_o` and sets `done_o`. After reset, all outputs are 0.
- R2: `busy_o` is 1 from the cycle in which the start bit is confirmed until the stop bit is sampled, and 0 while the line is idle.
- R3: A high-to-low transition of the line that is back high by the centre of the start bit is rejected. No frame is received and `busy_o` stays 0.
- R4: With `par_en_i`=1, the bit after the data is a parity bit. `par_odd_i`=0 selects even parity, meaning the data bits plus the parity bit contain an even number of ones. `par_odd_i`=1 selects odd parity. On a mismatch, `perr_o` is set together with `done_o`. With `par_en_i`=0 there is no parity bit and `perr_o` stays 0.
- R5: A stop bit sampled low sets `ferr_o`. The data is still loaded into the buffer.
- R6: `esum_o` equals the OR of `perr_o`, `ferr_o` and `ovr_o`.
- R7: While `ovr_o`=0, a one-cycle pulse on `buf_rd_i` clears `done_o`, `perr_o` and `ferr_o`.
- R8: If a frame completes while `done_o`=1 and no read occurs in the same cycle, `ovr_o` is set. The new data is discarded and `rbuf_o` keeps its value.
- R9: While `ovr_o`=1, later frames do not change `rbuf_o`. A buffer read then leaves `done_o`, `perr_o`, `ferr_o` and `ovr_o` unchanged.
- R10: Driving `rx_en_i` to 0 clears `done_o`, `perr_o`, `ferr_o` and `ovr_o` on the next cycle. It also aborts any frame in progress, which drives `busy_o` to 0. `rbuf_o` keeps its value. Dropping `rx_en_i` is the only way to clear `ovr_o`.
- R11: While `rx_en_i`=0, activity on the line receives nothing and leaves `rbuf_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_i | input | 1 | Serial line, idle high, asynchronous to the clock |
| rx_en_i | input | 1 | Receive enable |
| par_en_i | input | 1 | 1: a parity bit follows the data |
| par_odd_i | input | 1 | 0: even parity, 1: odd parity |
| buf_rd_i | input | 1 | One-cycle strobe: the host read the receive buffer |
| rbuf_o | output | 8 | Receive buffer register |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Character finished and not yet read |
| perr_o | output | 1 | Parity error of the buffered character |
| ferr_o | output | 1 | Framing error of the buffered character |
| ovr_o | output | 1 | Overrun, sticky until receive enable drops |
| esum_o | output | 1 | OR of the three error flags |

## Verification
The assertions assume that `buf_rd_i` is a single-cycle pulse and that the host does not change `par_en_i` or `par_odd_i` during a frame. They also assume that `baud_tick_i` pulses for one cycle at a time. The bench respects all three. It generates the tick from a fixed divider and changes parity settings only while the line is idle. It holds each line level for a whole bit time so that every centre sample falls well inside a bit. It also reads the buffer only between frames, so a read never lands in the same cycle as a frame completing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

endpackage

// File: rtl/uart_rx_rst_sync.sv
module uart_rx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sn_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sn_o = stage_q[1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              busy_o,
  output logic              vld_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

  // two-flop synchronizer for the asynchronous line
  logic rx_m_q, rx_s_q;
  logic prev_q, prev_d;

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [DATA_W-1:0]  shf_q, shf_d;
  logic               pacc_q, pacc_d;
  logic               vld_q, vld_d;
  logic               perr_q, perr_d;
  logic               ferr_q, ferr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_m_q <= 1'b1;
      rx_s_q <= 1'b1;
    end else begin
      rx_m_q <= rx_i;
      rx_s_q <= rx_m_q;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    pacc_d  = pacc_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    vld_d   = 1'b0;
    prev_d  = tick_i ? rx_s_q : prev_q;

    if (!en_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (prev_q && !rx_s_q) begin
            state_d = ST_START;
            cnt_d   = '0;
          end
        end
        ST_START: begin
          if (cnt_q == MID) begin
            cnt_d  = '0;
            idx_d  = '0;
            pacc_d = 1'b0;
            state_d = rx_s_q ? ST_IDLE : ST_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == LAST) begin
            cnt_d  = '0;
            shf_d  = {rx_s_q, shf_q[DATA_W-1:1]};
            pacc_d = pacc_q ^ rx_s_q;
            if (idx_q == TOP) begin
              state_d = par_en_i ? ST_PAR : ST_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            pacc_d  = pacc_q ^ rx_s_q;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt_q == LAST) begin
            cnt_d   = '0;
            vld_d   = 1'b1;
            ferr_d  = !rx_s_q;
            perr_d  = par_en_i && (pacc_q != par_odd_i);
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      pacc_q  <= 1'b0;
      vld_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      pacc_q  <= pacc_d;
      vld_q   <= vld_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      prev_q  <= prev_d;
    end
  end

  assign busy_o = (state_q == ST_DATA) || (state_q == ST_PAR) || (state_q == ST_STOP);
  assign vld_o  = vld_q;
  assign data_o = shf_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rbuf_o,
  output logic              done_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              esum_o
);

  logic [DATA_W-1:0] rbuf_q;
  logic done_q, done_d;
  logic perr_q, perr_d;
  logic ferr_q, ferr_d;
  logic ovr_q, ovr_d;
  logic esum_q, esum_d;
  logic load, clash;

  // a read in the same cycle as a completion frees the buffer first
  assign load  = en_i && vld_i && !ovr_q && (!done_q || rd_i);
  assign clash = en_i && vld_i && !ovr_q && done_q && !rd_i;

  always_comb begin
    done_d = done_q;
    perr_d = perr_q;
    ferr_d = ferr_q;
    ovr_d  = ovr_q;
    if (!en_i) begin
      done_d = 1'b0;
      perr_d = 1'b0;
      ferr_d = 1'b0;
      ovr_d  = 1'b0;
    end else if (load) begin
      done_d = 1'b1;
      perr_d = perr_i;
      ferr_d = ferr_i;
    end else if (clash) begin
      ovr_d = 1'b1;
    end else if (rd_i && !ovr_q) begin
      done_d = 1'b0;
      perr_d = 1'b0;
      ferr_d = 1'b0;
    end
    esum_d = perr_d | ferr_d | ovr_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q <= '0;
    end else if (load) begin
      rbuf_q <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
      esum_q <= 1'b0;
    end else begin
      done_q <= done_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      ovr_q  <= ovr_d;
      esum_q <= esum_d;
    end
  end

  assign rbuf_o = rbuf_q;
  assign done_o = done_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
  assign ovr_o  = ovr_q;
  assign esum_o = esum_q;

endmodule

// File: rtl/uart_rx.sv
module uart_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              buf_rd_i,
  output logic [DATA_W-1:0] rbuf_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              esum_o
);

  logic              rst_sn;
  logic              frm_vld;
  logic [DATA_W-1:0] frm_data;
  logic              frm_perr;
  logic              frm_ferr;

  uart_rx_rst_sync u_rst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rst_sn_o (rst_sn)
  );

  uart_rx_frame #(
    .DATA_W (DATA_W),
    .OVS    (OVS)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_sn),
    .tick_i    (baud_tick_i),
    .rx_i      (rx_i),
    .en_i      (rx_en_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .busy_o    (busy_o),
    .vld_o     (frm_vld),
    .data_o    (frm_data),
    .perr_o    (frm_perr),
    .ferr_o    (frm_ferr)
  );

  uart_rx_status #(
    .DATA_W (DATA_W)
  ) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .en_i   (rx_en_i),
    .vld_i  (frm_vld),
    .data_i (frm_data),
    .perr_i (frm_perr),
    .ferr_i (frm_ferr),
    .rd_i   (buf_rd_i),
    .rbuf_o (rbuf_o),
    .done_o (done_o),
    .perr_o (perr_o),
    .ferr_o (ferr_o),
    .ovr_o  (ovr_o),
    .esum_o (esum_o)
  );

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              rx_en_i,
  input logic              buf_rd_i,
  input logic              frm_vld,
  input logic [DATA_W-1:0] rbuf_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              perr_o,
  input logic              ferr_o,
  input logic              ovr_o,
  input logic              esum_o
);

  // R6
  esum_match_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    esum_o == (perr_o | ferr_o | ovr_o));

  // R8
  ovr_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovr_o |-> done_o);

  // R9
  ovr_keeps_buf_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovr_o |=> $stable(rbuf_o));

  // R10
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ovr_o && rx_en_i) |=> ovr_o);

  // R10
  disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !rx_en_i |=> (!ovr_o && !done_o && !perr_o && !ferr_o && !busy_o));

  // R7
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (buf_rd_i && rx_en_i && !ovr_o && !frm_vld) |=> (!done_o && !perr_o && !ferr_o));

endmodule

bind uart_rx uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_sn),
  .rx_en_i  (rx_en_i),
  .buf_rd_i (buf_rd_i),
  .frm_vld  (frm_vld),
  .rbuf_o   (rbuf_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .perr_o   (perr_o),
  .ferr_o   (ferr_o),
  .ovr_o    (ovr_o),
  .esum_o   (esum_o)
);

// File: tb/uart_rx_tb.sv
`timescale 1ns/1ps
module uart_rx_tb;

  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       rx;
  logic       en;
  logic       pen;
  logic       podd;
  logic       rd;
  logic [7:0] rbuf;
  logic       busy, done, perr, ferr, ovr, esum;

  int total = 0;
  int bad   = 0;
  logic busy_mid;
  logic [$clog2(TICK_DIV)-1:0] div_q;

  uart_rx u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .baud_tick_i (tick),
    .rx_i        (rx),
    .rx_en_i     (en),
    .par_en_i    (pen),
    .par_odd_i   (podd),
    .buf_rd_i    (rd),
    .rbuf_o      (rbuf),
    .busy_o      (busy),
    .done_o      (done),
    .perr_o      (perr),
    .ferr_o      (ferr),
    .ovr_o       (ovr),
    .esum_o      (esum)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= (div_q == '0);
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    @(posedge clk);
    rx <= v;
    repeat (BIT_CLK / 2) @(posedge clk);
    @(negedge clk);
    busy_mid = busy;
    repeat (BIT_CLK / 2 - 1) @(posedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic use_par, input logic flip_par,
                      input logic stop_b, output logic mid_busy);
    logic pb;
    pb = (podd ? ~^d : ^d) ^ flip_par;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) begin
      drive_bit(d[i]);
      if (i == 4) mid_busy = busy_mid;
    end
    if (use_par) drive_bit(pb);
    drive_bit(stop_b);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic do_read();
    @(posedge clk);
    rd <= 1'b1;
    @(posedge clk);
    rd <= 1'b0;
    @(negedge clk);
  endtask

  task automatic toggle_en();
    @(posedge clk);
    en <= 1'b0;
    repeat (3) @(posedge clk);
    en <= 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rbuf == 8'h00, "R1 reset rbuf", rbuf, 0);
    chk({busy, done, perr, ferr, ovr, esum} == 6'b0, "R1 reset flags",
        {busy, done, perr, ferr, ovr, esum}, 0);
  endtask

  task automatic t_basic();
    logic mb;
    send(8'hA5, 1'b0, 1'b0, 1'b1, mb);
    @(negedge clk);
    chk(mb == 1'b1, "R2 busy mid frame", mb, 1);
    chk(busy == 1'b0, "R2 busy idle", busy, 0);
    chk(rbuf == 8'hA5, "R1 data", rbuf, 8'hA5);
    chk(done == 1'b1, "R1 done", done, 1);
    chk(esum == 1'b0, "R6 esum clean", esum, 0);
    chk(perr == 1'b0, "R4 no parity", perr, 0);
    do_read();
    chk(done == 1'b0, "R7 read clears done", done, 0);
  endtask

  task automatic t_parity();
    logic mb;
    pen = 1'b1; podd = 1'b0;
    send(8'h3C, 1'b1, 1'b0, 1'b1, mb);
    @(negedge clk);
    chk(rbuf == 8'h3C && perr == 1'b0, "R4 even ok", {rbuf, perr}, {8'h3C, 1'b0});
    do_read();
    send(8'h07, 1'b1, 1'b1, 1'b1, mb);
    @(negedge clk);
    chk(perr == 1'b1, "R4 even bad", perr, 1);
    chk(esum == 1'b1, "R6 esum parity", esum, 1);
    do_read();
    chk(perr == 1'b0 && done == 1'b0, "R7 read clears perr", {perr, done}, 0);
    podd = 1'b1;
    send(8'h5A, 1'b1, 1'b0, 1'b1, mb);
    @(negedge clk);
    chk(rbuf == 8'h5A && perr == 1'b0, "R4 odd ok", {rbuf, perr}, {8'h5A, 1'b0});
    do_read();
    send(8'h5B, 1'b1, 1'b1, 1'b1, mb);
    @(negedge clk);
    chk(perr == 1'b1, "R4 odd bad", perr, 1);
    do_read();
    pen = 1'b0; podd = 1'b0;
  endtask

  task automatic t_framing();
    logic mb;
    send(8'hC3, 1'b0, 1'b0, 1'b0, mb);
    @(negedge clk);
    chk(ferr == 1'b1, "R5 ferr set", ferr, 1);
    chk(rbuf == 8'hC3, "R5 data kept", rbuf, 8'hC3);
    chk(esum == 1'b1, "R6 esum framing", esum, 1);
    do_read();
    chk(ferr == 1'b0, "R7 read clears ferr", ferr, 0);
  endtask

  task automatic t_glitch();
    logic b;
    b = 1'b0;
    @(posedge clk);
    rx <= 1'b0;
    repeat (4 * TICK_DIV) @(posedge clk);
    rx <= 1'b1;
    for (int i = 0; i < 3 * BIT_CLK; i++) begin
      @(negedge clk);
      b = b | busy;
    end
    chk(b == 1'b0, "R3 glitch busy", b, 0);
    chk(done == 1'b0, "R3 glitch no frame", done, 0);
  endtask

  task automatic t_overrun();
    logic mb;
    toggle_en();
    send(8'h11, 1'b0, 1'b0, 1'b1, mb);
    send(8'h22, 1'b0, 1'b0, 1'b1, mb);
    @(negedge clk);
    chk(ovr == 1'b1, "R8 ovr set", ovr, 1);
    chk(rbuf == 8'h11, "R8 old data kept", rbuf, 8'h11);
    chk(done == 1'b1 && esum == 1'b1, "R8 done esum", {done, esum}, 2'b11);
    send(8'h33, 1'b0, 1'b0, 1'b1, mb);
    @(negedge clk);
    chk(rbuf == 8'h11, "R9 later frame dropped", rbuf, 8'h11);
    do_read();
    chk({done, ovr, esum} == 3'b111, "R9 read ignored", {done, ovr, esum}, 3'b111);
    toggle_en();
    chk({done, perr, ferr, ovr, esum} == 5'b0, "R10 disable clears",
        {done, perr, ferr, ovr, esum}, 0);
    chk(rbuf == 8'h11, "R10 buffer held", rbuf, 8'h11);
    send(8'h44, 1'b0, 1'b0, 1'b1, mb);
    @(negedge clk);
    chk(rbuf == 8'h44 && ovr == 1'b0, "R10 normal again", {rbuf, ovr}, {8'h44, 1'b0});
    do_read();
  endtask

  task automatic t_abort();
    logic mb;
    drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b0);
    chk(busy == 1'b1, "R2 busy partial", busy, 1);
    @(posedge clk);
    en <= 1'b0;
    @(posedge clk);
    rx <= 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10 abort busy", busy, 0);
    repeat (BIT_CLK) @(posedge clk);
    en <= 1'b1;
    send(8'h96, 1'b0, 1'b0, 1'b1, mb);
    @(negedge clk);
    chk(rbuf == 8'h96 && ferr == 1'b0, "R10 clean after abort", {rbuf, ferr}, {8'h96, 1'b0});
    do_read();
  endtask

  task automatic t_disabled();
    logic mb;
    @(posedge clk);
    en <= 1'b0;
    send(8'h77, 1'b0, 1'b0, 1'b1, mb);
    @(negedge clk);
    chk(mb == 1'b0, "R11 no busy", mb, 0);
    chk(done == 1'b0 && rbuf == 8'h96, "R11 nothing received", {done, rbuf}, {1'b0, 8'h96});
    en <= 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    rx = 1'b1; en = 1'b0; pen = 1'b0; podd = 1'b0; rd = 1'b0;
    busy_mid = 1'b0;
    repeat (5) @(posedge clk);
    rst_n <= 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    en <= 1'b1;
    repeat (BIT_CLK) @(posedge clk);
    t_basic();
    t_parity();
    t_framing();
    t_glitch();
    t_overrun();
    t_abort();
    t_disabled();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule